// File: doc/BRIEF.md
# Uplink Frame Encoder with Selectable Reed-Solomon Protection

This block assembles one 128-bit uplink frame per frame-clock cycle from a user data word and two 2-bit slow-control fields: an internal-control (IC) field and an external-control (EC) field. A select input picks one of two protection schemes for each frame, and the choice can change from one frame to the next. The "wide" scheme carries 112 data bits and protects them with one shortened Reed-Solomon code over 5-bit symbols. The "interleaved" scheme carries 96 data bits and protects them with three interleaved Reed-Solomon codes over 4-bit symbols. In both schemes the frame begins with a fixed 2-bit header. The header is not covered by the parity.

Parity is computed combinationally from the incoming fields. The complete frame is registered on a clock edge where `in_valid` is high. A two-state controller tracks whether the frame register holds a frame that was loaded on the most recent edge.

- **ST_IDLE**: no new frame this cycle.
- **ST_LIVE**: a frame was loaded on the last edge.
- **Transition to ST_LIVE**: taken from either state on an edge with `in_valid` high.
- **Transition to ST_IDLE**: taken from either state on an edge with `in_valid` low.
- **Reset**: places the controller in ST_IDLE.

Top module: `ulframe_encoder`

## Requirements
- R1: In every loaded frame, bits [127:126] are the header 2'b10.
- R2: Bits [125:124] carry `ic_bits` and bits [123:122] carry `ec_bits`, both taken from the loading edge.
- R3: With `fec_mode` = 0 (wide scheme), bits [121:10] equal `data_in[111:0]`.
- R4: With `fec_mode` = 0, take the 120-bit string {4'b0, frame[125:10]} and split it into 24 five-bit symbols, most significant first. Append frame[9:5] and then frame[4:0]. The resulting polynomial has roots alpha and alpha^2 in GF(32), where the field polynomial is x^5+x^2+1 and alpha = 2.
- R5: With `fec_mode` = 1 (interleaved scheme), bits [121:26] equal `data_in[95:0]` and bits [25:24] are zero. `data_in[111:96]` has no effect on the frame.
- R6: With `fec_mode` = 1, split frame[125:26] into 25 nibbles, with nibble k = 0 the most significant. Nibble k belongs to codeword k mod 3.
  - For codeword j, the first parity nibble is frame[(5-j)*4 +: 4] and the second is frame[(2-j)*4 +: 4].
  - Each codeword (its nibbles in order, then its two parity nibbles) has roots alpha and alpha^2 in GF(16), where the field polynomial is x^4+x+1 and alpha = 2.
- R7: A frame presented with `in_valid` high is visible on `frame_out` one clock later, and `frame_valid` is high in that same cycle.
- R8: After an edge with `in_valid` low, `frame_out` keeps its previous value and `frame_valid` is low.
- R9: While reset is asserted, `frame_out` is all zeros and `frame_valid` is low.
- R10: `fec_mode` is sampled per frame, so back-to-back frames in alternating schemes are each encoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fec_mode | input | 1 | 0 = wide scheme, 1 = interleaved scheme |
| data_in | input | 112 | User data word; only bits [95:0] are used in the interleaved scheme |
| ic_bits | input | 2 | Internal-control field |
| ec_bits | input | 2 | External-control field |
| in_valid | input | 1 | Load a frame on this edge |
| frame_out | output | 128 | Registered frame, bit 127 sent first |
| frame_valid | output | 1 | High when frame_out was loaded on the last edge |

## Verification
Every result of this block is due exactly one clock edge after its stimulus, because the only registers on the path are the frame register and the controller state. The bench drives inputs on a falling edge and samples on the next falling edge, which falls after the single capturing rising edge. Parity is not compared against a reference encoder. Instead, the bench evaluates the syndromes of each captured codeword at alpha and alpha^2 using its own field arithmetic. The hold case waits two further edges with `in_valid` low before it compares the frame.

// File: rtl/ulfec_pkg.sv
package ulfec_pkg;

    localparam int          FRAME_W   = 128;
    localparam int          HDR_W     = 2;
    localparam int          CTRL_W    = 2;
    localparam logic [1:0]  HDR_VALUE = 2'b10;

    localparam int          WIDE_DATA_W = 112;
    localparam int          WIDE_SYM_W  = 5;
    localparam logic [4:0]  WIDE_RED    = 5'h05;   // x^5+x^2+1, low terms

    localparam int          ILV_DATA_W  = 96;
    localparam int          ILV_SYM_W   = 4;
    localparam int          ILV_LANES   = 3;
    localparam logic [4:0]  ILV_RED     = 5'h03;   // x^4+x+1, low terms

    typedef enum logic {
        SCHEME_WIDE = 1'b0,
        SCHEME_ILV  = 1'b1
    } scheme_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } enc_state_e;

    // Multiply in GF(2^w), w of 4 or 5, reduction terms given in red.
    function automatic logic [4:0] gf_mul(input logic [4:0] a, input logic [4:0] b,
                                          input int w, input logic [4:0] red);
        logic [4:0] acc;
        logic [4:0] x;
        logic [4:0] mask;
        logic       carry;
        acc  = '0;
        x    = a;
        mask = (w == 5) ? 5'h1f : 5'h0f;
        for (int i = 0; i < 5; i++) begin
            if (i < w && b[i]) acc = acc ^ x;
            carry = (w == 5) ? x[4] : x[3];
            x     = (x << 1) & mask;
            if (carry) x = x ^ red;
        end
        return acc & mask;
    endfunction

endpackage

// File: rtl/ulfec_rs_parity2.sv
module ulfec_rs_parity2 #(
    parameter int         SYM_W = 5,
    parameter int         N_SYM = 24,
    parameter logic [4:0] RED   = 5'h05
) (
    input  logic [N_SYM*SYM_W-1:0] msg,
    output logic [2*SYM_W-1:0]     parity
);
    import ulfec_pkg::*;

    // generator (x+a)(x+a^2): coefficients a+a^2 = 6 and a^3 = 8
    localparam logic [4:0] GEN_1 = 5'd6;
    localparam logic [4:0] GEN_0 = 5'd8;

    logic [4:0] reg_hi;
    logic [4:0] reg_lo;

    always_comb begin
        logic [4:0] sym;
        logic [4:0] fb;
        reg_hi = '0;
        reg_lo = '0;
        for (int k = 0; k < N_SYM; k++) begin
            sym = '0;
            sym[SYM_W-1:0] = msg[(N_SYM-1-k)*SYM_W +: SYM_W];
            fb     = sym ^ reg_hi;
            reg_hi = reg_lo ^ gf_mul(fb, GEN_1, SYM_W, RED);
            reg_lo = gf_mul(fb, GEN_0, SYM_W, RED);
        end
    end

    assign parity = {reg_hi[SYM_W-1:0], reg_lo[SYM_W-1:0]};

endmodule

// File: rtl/ulfec_wide_code.sv
module ulfec_wide_code #(
    parameter int PAY_W = 116
) (
    input  logic [PAY_W-1:0]                 payload,
    output logic [2*ulfec_pkg::WIDE_SYM_W-1:0] parity
);
    import ulfec_pkg::*;

    localparam int N_SYM = (PAY_W + WIDE_SYM_W - 1) / WIDE_SYM_W;
    localparam int PAD_W = N_SYM * WIDE_SYM_W - PAY_W;

    logic [N_SYM*WIDE_SYM_W-1:0] msg;

    generate
        if (PAD_W > 0) begin : g_pad
            assign msg = {{PAD_W{1'b0}}, payload};
        end else begin : g_nopad
            assign msg = payload;
        end
    endgenerate

    ulfec_rs_parity2 #(
        .SYM_W (WIDE_SYM_W),
        .N_SYM (N_SYM),
        .RED   (WIDE_RED)
    ) u_rs (
        .msg    (msg),
        .parity (parity)
    );

endmodule

// File: rtl/ulfec_ilv_code.sv
module ulfec_ilv_code #(
    parameter int PAY_W = 100
) (
    input  logic [PAY_W-1:0]                                      payload,
    output logic [2*ulfec_pkg::ILV_LANES*ulfec_pkg::ILV_SYM_W-1:0] parity
);
    import ulfec_pkg::*;

    localparam int TOTAL     = PAY_W / ILV_SYM_W;
    localparam int LANE_SYMS = (TOTAL + ILV_LANES - 1) / ILV_LANES;

    generate
        for (genvar j = 0; j < ILV_LANES; j++) begin : g_lane
            localparam int CNT = (TOTAL - j + ILV_LANES - 1) / ILV_LANES;
            localparam int PAD = LANE_SYMS - CNT;

            logic [LANE_SYMS*ILV_SYM_W-1:0] lane_msg;
            logic [2*ILV_SYM_W-1:0]         lane_par;

            // nibbles k = j, j+3, ... in order; leading zero symbols pad short lanes
            always_comb begin
                lane_msg = '0;
                for (int i = PAD; i < LANE_SYMS; i++) begin
                    lane_msg[(LANE_SYMS-1-i)*ILV_SYM_W +: ILV_SYM_W] =
                        payload[(TOTAL-1-((i-PAD)*ILV_LANES+j))*ILV_SYM_W +: ILV_SYM_W];
                end
            end

            ulfec_rs_parity2 #(
                .SYM_W (ILV_SYM_W),
                .N_SYM (LANE_SYMS),
                .RED   (ILV_RED)
            ) u_rs (
                .msg    (lane_msg),
                .parity (lane_par)
            );

            assign parity[(2*ILV_LANES-1-j)*ILV_SYM_W +: ILV_SYM_W] = lane_par[2*ILV_SYM_W-1 -: ILV_SYM_W];
            assign parity[(ILV_LANES-1-j)*ILV_SYM_W   +: ILV_SYM_W] = lane_par[ILV_SYM_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/ulframe_encoder.sv
module ulframe_encoder (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fec_mode,
    input  logic [111:0] data_in,
    input  logic [1:0]   ic_bits,
    input  logic [1:0]   ec_bits,
    input  logic         in_valid,
    output logic [127:0] frame_out,
    output logic         frame_valid
);
    import ulfec_pkg::*;

    localparam int WIDE_PAY_W = 2*CTRL_W + WIDE_DATA_W;
    localparam int ILV_PAY_W  = 2*CTRL_W + ILV_DATA_W;
    localparam int WIDE_PAR_W = 2*WIDE_SYM_W;
    localparam int ILV_PAR_W  = 2*ILV_LANES*ILV_SYM_W;
    localparam int SPARE_W    = FRAME_W - HDR_W - ILV_PAY_W - ILV_PAR_W;

    scheme_e    scheme;
    enc_state_e state_q, state_d;

    logic [2*CTRL_W-1:0]  ctrl_f;
    logic [WIDE_PAR_W-1:0] wide_par;
    logic [ILV_PAR_W-1:0]  ilv_par;
    logic [FRAME_W-1:0]   frame_d, frame_q;

    assign scheme = scheme_e'(fec_mode);
    assign ctrl_f = {ic_bits, ec_bits};

    ulfec_wide_code #(.PAY_W(WIDE_PAY_W)) u_wide (
        .payload ({ctrl_f, data_in[WIDE_DATA_W-1:0]}),
        .parity  (wide_par)
    );

    ulfec_ilv_code #(.PAY_W(ILV_PAY_W)) u_ilv (
        .payload ({ctrl_f, data_in[ILV_DATA_W-1:0]}),
        .parity  (ilv_par)
    );

    always_comb begin
        unique case (scheme)
            SCHEME_WIDE: frame_d = {HDR_VALUE, ctrl_f, data_in[WIDE_DATA_W-1:0], wide_par};
            SCHEME_ILV:  frame_d = {HDR_VALUE, ctrl_f, data_in[ILV_DATA_W-1:0],
                                    {SPARE_W{1'b0}}, ilv_par};
        endcase
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_LIVE : ST_IDLE;
            ST_LIVE: state_d = in_valid ? ST_LIVE : ST_IDLE;
        endcase
    end

    // state register and frame register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) frame_q <= frame_d;
        end
    end

    // outputs
    always_comb begin
        frame_out = frame_q;
        unique case (state_q)
            ST_IDLE: frame_valid = 1'b0;
            ST_LIVE: frame_valid = 1'b1;
        endcase
    end

    p_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> frame_out[127:126] == 2'b10);

    p_ctrl_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> frame_valid && frame_out[125:122] == $past({ic_bits, ec_bits}));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(frame_out) && !frame_valid);

    p_wide_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fec_mode) |=> frame_out[121:10] == $past(data_in));

    p_ilv_spare_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fec_mode) |=> frame_out[25:24] == 2'b00 &&
                                   frame_out[121:26] == $past(data_in[95:0]));

endmodule

// File: tb/tb_ulframe_encoder.sv
`timescale 1ns/1ps
module tb_ulframe_encoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fec_mode = 1'b0;
    logic [111:0] data_in = '0;
    logic [1:0]   ic_bits = '0;
    logic [1:0]   ec_bits = '0;
    logic         in_valid = 1'b0;
    logic [127:0] frame_out;
    logic         frame_valid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    ulframe_encoder dut (
        .clk(clk), .rst_n(rst_n), .fec_mode(fec_mode), .data_in(data_in),
        .ic_bits(ic_bits), .ec_bits(ec_bits), .in_valid(in_valid),
        .frame_out(frame_out), .frame_valid(frame_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // polynomial product then long-division reduction
    function automatic int gmul(input int a, input int b, input int w, input int poly);
        int prod = 0;
        for (int i = 0; i < w; i++) if ((b >> i) & 1) prod = prod ^ (a << i);
        for (int bitp = 2*w-2; bitp >= w; bitp--)
            if ((prod >> bitp) & 1) prod = prod ^ (poly << (bitp - w));
        return prod;
    endfunction

    function automatic int syn_wide(input logic [127:0] f, input int root);
        logic [119:0] m;
        int s = 0;
        m = {4'b0, f[125:10]};
        for (int k = 0; k < 24; k++) s = gmul(s, root, 5, 'h25) ^ int'(m[(23-k)*5 +: 5]);
        s = gmul(s, root, 5, 'h25) ^ int'(f[9:5]);
        s = gmul(s, root, 5, 'h25) ^ int'(f[4:0]);
        return s;
    endfunction

    function automatic int syn_ilv(input logic [127:0] f, input int lane, input int root);
        logic [99:0] p;
        int s = 0;
        p = f[125:26];
        for (int k = 0; k < 25; k++)
            if (k % 3 == lane) s = gmul(s, root, 4, 'h13) ^ int'(p[(24-k)*4 +: 4]);
        s = gmul(s, root, 4, 'h13) ^ int'(f[(5-lane)*4 +: 4]);
        s = gmul(s, root, 4, 'h13) ^ int'(f[(2-lane)*4 +: 4]);
        return s;
    endfunction

    task automatic drive(input bit m, input logic [111:0] d, input logic [1:0] i, input logic [1:0] e);
        fec_mode = m; data_in = d; ic_bits = i; ec_bits = e; in_valid = 1'b1;
    endtask

    // checks the frame now on the output against the given stimulus
    task automatic check_frame(input bit m, input logic [111:0] d, input logic [1:0] i,
                               input logic [1:0] e, input string name);
        chk(frame_valid == 1'b1, {"R7 valid ", name}, 128'(frame_valid), 128'd1);
        chk(frame_out[127:126] == 2'b10, {"R1 header ", name}, 128'(frame_out[127:126]), 128'd2);
        chk(frame_out[125:122] == {i, e}, {"R2 ctrl ", name}, 128'(frame_out[125:122]), 128'({i, e}));
        if (!m) begin
            chk(frame_out[121:10] == d, {"R3 data ", name}, 128'(frame_out[121:10]), 128'(d));
            chk(syn_wide(frame_out, 2) == 0 && syn_wide(frame_out, 4) == 0,
                {"R4 syndrome ", name}, frame_out, 128'(0));
        end else begin
            chk(frame_out[121:26] == d[95:0], {"R5 data ", name}, 128'(frame_out[121:26]), 128'(d[95:0]));
            chk(frame_out[25:24] == 2'b00, {"R5 spare ", name}, 128'(frame_out[25:24]), 128'd0);
            for (int l = 0; l < 3; l++)
                chk(syn_ilv(frame_out, l, 2) == 0 && syn_ilv(frame_out, l, 4) == 0,
                    {"R6 syndrome ", name}, frame_out, 128'(l));
        end
    endtask

    task automatic one_frame(input bit m, input logic [111:0] d, input logic [1:0] i,
                             input logic [1:0] e, input string name);
        @(negedge clk);
        drive(m, d, i, e);
        @(negedge clk);
        in_valid = 1'b0;
        check_frame(m, d, i, e, name);
    endtask

    task automatic t_reset();
        chk(frame_out == '0, "R9 frame in reset", frame_out, '0);
        chk(frame_valid == 1'b0, "R9 valid in reset", 128'(frame_valid), '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_wide();
        one_frame(1'b0, '0, 2'b00, 2'b00, "wide zero");
        one_frame(1'b0, {112{1'b1}}, 2'b11, 2'b11, "wide ones");
        one_frame(1'b0, {56{2'b10}}, 2'b01, 2'b10, "wide alt");
        one_frame(1'b0, 112'd1 << 57, 2'b10, 2'b01, "wide onehot");
        one_frame(1'b0, 112'h0123_4567_89ab_cdef_fedc_ba98_7654, 2'b01, 2'b00, "wide mix");
    endtask

    task automatic t_ilv();
        logic [127:0] first;
        one_frame(1'b1, {16'h0000, 96'hdead_beef_0bad_cafe_1234_5678}, 2'b10, 2'b11, "ilv a");
        first = frame_out;
        // R5: upper 16 data bits must not change the frame
        one_frame(1'b1, {16'hffff, 96'hdead_beef_0bad_cafe_1234_5678}, 2'b10, 2'b11, "ilv b");
        chk(frame_out == first, "R5 upper bits ignored", frame_out, first);
        one_frame(1'b1, {112{1'b1}}, 2'b11, 2'b11, "ilv ones");
        one_frame(1'b1, 112'd1 << 3, 2'b00, 2'b01, "ilv onehot");
    endtask

    task automatic t_hold();
        logic [127:0] held;
        one_frame(1'b0, 112'h5555_aaaa_0000_ffff_1111_2222_3333, 2'b01, 2'b01, "hold src");
        held = frame_out;
        data_in = ~data_in; fec_mode = 1'b1; ic_bits = 2'b10;
        @(negedge clk);
        @(negedge clk);
        chk(frame_out == held, "R8 frame held", frame_out, held);
        chk(frame_valid == 1'b0, "R8 valid low", 128'(frame_valid), '0);
    endtask

    task automatic t_switch();
        @(negedge clk);
        drive(1'b0, 112'h00ff_00ff_00ff_00ff_00ff_00ff_00ff, 2'b11, 2'b00);
        @(negedge clk);
        check_frame(1'b0, 112'h00ff_00ff_00ff_00ff_00ff_00ff_00ff, 2'b11, 2'b00, "R10 sw1");
        drive(1'b1, 112'h9999_8888_7777_6666_5555_4444_3333, 2'b00, 2'b11);
        @(negedge clk);
        check_frame(1'b1, 112'h9999_8888_7777_6666_5555_4444_3333, 2'b00, 2'b11, "R10 sw2");
        drive(1'b0, 112'hf0f0_0f0f_f0f0_0f0f_f0f0_0f0f_f0f0, 2'b01, 2'b11);
        @(negedge clk);
        check_frame(1'b0, 112'hf0f0_0f0f_f0f0_0f0f_f0f0_0f0f_f0f0, 2'b01, 2'b11, "R10 sw3");
        in_valid = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_wide();
        t_ilv();
        t_hold();
        t_switch();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule